// File: doc/BRIEF.md
# Addressable Bit Register with Demultiplexer

This block holds a small bank of single-bit storage cells, eight by default. One data bit is written into the cell picked by a binary address. Two active-low controls pick how each clock edge treats the bank. The bank can take a new value in one cell, keep every cell, clear every cell, or act as a one-hot demultiplexer. In the demultiplexer mode the addressed output copies the data bit and every other output is low. With the data bit tied high, that mode gives a binary-to-one-hot decoder.

Every cell is a flip-flop that samples on the rising clock edge. All inputs, the two controls included, are sampled only at that edge. The outputs are the flip-flop contents, so they show the effect of an edge right after it. The address is therefore free to move between edges without selecting a wrong cell. A synchronous reset, separate from the clear mode, empties the bank.

Top module: `addr_bit_latch`

## Requirements
- R1: The mode comes from the 2-bit code {clearN, enableN}: 2'b10 is single-cell write, 2'b11 is hold, 2'b00 is demultiplex and 2'b01 is clear.
- R2: In write mode the addressed cell takes dataIn and every other cell keeps its value.
- R3: In hold mode all cells keep their values, whatever dataIn and addrIn are.
- R4: In demultiplex mode the addressed cell takes dataIn and every other cell becomes 0. With dataIn at 1 the outputs are one-hot.
- R5: In clear mode all cells become 0, whatever dataIn and addrIn are.
- R6: The address is unsigned binary with bit 0 as its LSB. Address k selects output bit k, and an address of WIDTH or more selects no cell.
- R7: When rst is high at a rising edge, all cells become 0, whatever the mode.
- R8: Inputs act only at a rising edge. The outputs change right after that edge and stay unchanged until the next one.
- R9: When write mode ends in hold mode, a cell keeps the data it was given on the last write edge.
- R10: A demultiplex edge followed by hold edges leaves only the last addressed cell able to be 1, and holds that cell at the demultiplexed data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| dataIn | input | 1 | Data bit |
| addrIn | input | ADDR_W | Cell address, bit 0 LSB |
| enableN | input | 1 | Active-low enable |
| clearN | input | 1 | Active-low clear |
| bitsOut | output | WIDTH | Cell contents, active high |

## Verification
The bench uses the default WIDTH of 8, so ADDR_W is 3 and every address value selects a real cell. Random stimulus can therefore reach each address together with all four mode codes, random data and occasional resets. Directed sequences cover each decoder output, the last write value kept when hold starts, the pattern left after demultiplexing, and the outputs not moving between edges.

// File: rtl/abl_pkg.sv
package abl_pkg;
  // mode code is {clearN, enableN}
  typedef enum logic [1:0] {
    MODE_DEMUX = 2'b00,
    MODE_CLEAR = 2'b01,
    MODE_WRITE = 2'b10,
    MODE_HOLD  = 2'b11
  } ablMode_e;

  typedef struct packed {
    logic wrBit;    // update the addressed cell only
    logic loadAll;  // load one-hot pattern gated by data
    logic zeroAll;  // clear every cell
  } ablStrobe_t;
endpackage

// File: rtl/abl_ctrl.sv
module abl_ctrl
  import abl_pkg::*;
(
  input  logic       enableN,
  input  logic       clearN,
  output ablStrobe_t strb
);
  ablMode_e mode;

  always_comb begin
    mode = ablMode_e'({clearN, enableN});
    strb = '0;
    unique case (mode)
      MODE_WRITE: strb.wrBit   = 1'b1;
      MODE_DEMUX: strb.loadAll = 1'b1;
      MODE_CLEAR: strb.zeroAll = 1'b1;
      default:    strb         = '0;  // MODE_HOLD
    endcase
  end
endmodule

// File: rtl/abl_dec.sv
module abl_dec #(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = $clog2(WIDTH)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [WIDTH-1:0]  sel
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_sel
    assign sel[i] = (addr == ADDR_W'(i));
  end
endmodule

// File: rtl/abl_dp.sv
module abl_dp
  import abl_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  ablStrobe_t       strb,
  input  logic [WIDTH-1:0] sel,
  input  logic             dataIn,
  output logic [WIDTH-1:0] cells
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst)               cells[i] <= 1'b0;
      else if (strb.zeroAll) cells[i] <= 1'b0;
      else if (strb.loadAll) cells[i] <= sel[i] & dataIn;
      else if (strb.wrBit && sel[i]) cells[i] <= dataIn;
    end
  end

  AST_RESET_EMPTY: assert property (@(posedge clk) rst |=> cells == '0); // R7
  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (rst)
    strb.zeroAll |=> cells == '0); // R5
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (strb == '0) |=> $stable(cells)); // R3
  AST_WRITE_OTHERS: assert property (@(posedge clk) disable iff (rst)
    strb.wrBit |=> ((cells ^ $past(cells)) & ~$past(sel)) == '0); // R2
  AST_WRITE_TARGET: assert property (@(posedge clk) disable iff (rst)
    strb.wrBit |=> (cells & $past(sel)) == ($past(sel) & {WIDTH{$past(dataIn)}})); // R2
  AST_DEMUX_PATTERN: assert property (@(posedge clk) disable iff (rst)
    strb.loadAll |=> cells == ($past(sel) & {WIDTH{$past(dataIn)}})); // R4
  AST_DEMUX_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    strb.loadAll |=> $onehot0(cells)); // R4
endmodule

// File: rtl/addr_bit_latch.sv
module addr_bit_latch
  import abl_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = $clog2(WIDTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dataIn,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              enableN,
  input  logic              clearN,
  output logic [WIDTH-1:0]  bitsOut
);
  ablStrobe_t       strb;
  logic [WIDTH-1:0] sel;

  abl_ctrl u_ctrl (
    .enableN (enableN),
    .clearN  (clearN),
    .strb    (strb)
  );

  abl_dec #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_dec (
    .addr (addrIn),
    .sel  (sel)
  );

  abl_dp #(.WIDTH(WIDTH)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strb   (strb),
    .sel    (sel),
    .dataIn (dataIn),
    .cells  (bitsOut)
  );

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel)); // R6
endmodule

// File: tb/tb_addr_bit_latch.sv
module tb_addr_bit_latch;
  localparam int W  = 8;
  localparam int AW = $clog2(W);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          dataIn = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic          enableN = 1'b1;
  logic          clearN = 1'b1;
  logic [W-1:0]  bitsOut;

  int nChecks = 0;
  int nFails  = 0;
  logic [W-1:0] model = '0;

  always #10 clk = ~clk;  // 50 MHz

  addr_bit_latch #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .dataIn(dataIn), .addrIn(addrIn),
    .enableN(enableN), .clearN(clearN), .bitsOut(bitsOut)
  );

  // reference: mode code {clearN, enableN}: 10 write, 11 hold, 00 demux, 01 clear
  function automatic logic [W-1:0] refNext(logic [W-1:0] cur, logic r, logic en,
                                           logic cl, logic [AW-1:0] a, logic d);
    logic [W-1:0] nxt;
    nxt = cur;
    if (r) nxt = '0;
    else begin
      case ({cl, en})
        2'b10: nxt[a] = d;
        2'b00: begin nxt = '0; nxt[a] = d; end
        2'b01: nxt = '0;
        default: nxt = cur;
      endcase
    end
    return nxt;
  endfunction

  function automatic string modeTag(logic r, logic en, logic cl);
    if (r) return "R7";
    case ({cl, en})
      2'b10: return "R1/R2";
      2'b11: return "R1/R3";
      2'b00: return "R1/R4";
      default: return "R1/R5";
    endcase
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // drive at negedge, apply one edge, sample 1 ns after it
  task automatic step(logic r, logic en, logic cl, logic [AW-1:0] a, logic d, string tag);
    @(negedge clk);
    rst = r; enableN = en; clearN = cl; addrIn = a; dataIn = d;
    model = refNext(model, r, en, cl, a, d);
    @(posedge clk);
    #1;
    check(tag, bitsOut, model);
  endtask

  logic done = 1'b0;

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd2024));
    // reset state R7
    step(1'b1, 1'b0, 1'b1, 3'd2, 1'b1, "R7");
    step(1'b1, 1'b1, 1'b1, 3'd0, 1'b0, "R7");

    // R6: each address decodes to its own output with data high
    for (int k = 0; k < W; k++)
      step(1'b0, 1'b0, 1'b0, AW'(k), 1'b1, "R6");

    // R2: fill all ones by writes, then write a zero in the middle
    for (int k = 0; k < W; k++)
      step(1'b0, 1'b0, 1'b1, AW'(k), 1'b1, "R2");
    step(1'b0, 1'b0, 1'b1, 3'd4, 1'b0, "R2");

    // R3: hold ignores data and address changes
    step(1'b0, 1'b1, 1'b1, 3'd4, 1'b1, "R3");
    step(1'b0, 1'b1, 1'b1, 3'd7, 1'b0, "R3");

    // R8: between edges the output does not follow new inputs
    @(negedge clk);
    enableN = 1'b0; clearN = 1'b1; addrIn = 3'd4; dataIn = 1'b1;
    #5 check("R8", bitsOut, model);
    model = refNext(model, 1'b0, 1'b0, 1'b1, 3'd4, 1'b1);
    @(posedge clk); #1 check("R8", bitsOut, model);

    // R9: last write edge value is kept in hold
    step(1'b0, 1'b0, 1'b1, 3'd3, 1'b1, "R9");
    step(1'b0, 1'b0, 1'b1, 3'd3, 1'b0, "R9");
    step(1'b0, 1'b1, 1'b1, 3'd3, 1'b1, "R9");
    check("R9", bitsOut, 8'b1111_0111);

    // R10: demux then hold leaves only the demuxed cell
    step(1'b0, 1'b0, 1'b0, 3'd5, 1'b1, "R10");
    step(1'b0, 1'b1, 1'b1, 3'd1, 1'b0, "R10");
    check("R10", bitsOut, 8'b0010_0000);

    // R4: demux with data low empties everything
    step(1'b0, 1'b0, 1'b0, 3'd5, 1'b0, "R4");
    check("R4", bitsOut, 8'h00);

    // R5: clear ignores data and address
    step(1'b0, 1'b0, 1'b1, 3'd6, 1'b1, "R5");
    step(1'b0, 1'b1, 1'b0, 3'd6, 1'b1, "R5");
    check("R5", bitsOut, 8'h00);

    // R7: reset overrides write mode
    step(1'b0, 1'b0, 1'b1, 3'd1, 1'b1, "R7");
    step(1'b1, 1'b0, 1'b1, 3'd2, 1'b1, "R7");

    // random mix of modes, addresses, data and rare resets
    for (int n = 0; n < 3000; n++) begin
      logic r, en, cl, d;
      logic [AW-1:0] a;
      r  = ($urandom % 64) == 0;
      en = $urandom % 2;
      cl = ($urandom % 5) != 0;
      d  = $urandom % 2;
      a  = AW'($urandom);
      step(r, en, cl, a, d, modeTag(r, en, cl));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule